// File: doc/BRIEF.md
# Wide-to-Narrow Store Splitter Bridge

This bridge connects a 64-bit pipelined upstream port driven by a processor core to a 32-bit downstream IO bus. It takes one upstream request at a time. It turns that request into one or two 32-bit downstream accesses, depending on which byte lanes the request selects. When the last downstream access completes, the bridge returns exactly one acknowledge upstream. For reads, that acknowledge carries the assembled 64-bit data.

The whole request is registered on the cycle it is accepted: write data, byte selects, write flag and address. Once a request is taken, the upstream lines may already show the next command. The second downstream access is therefore always built from the registered copy and never from the live upstream inputs. While a request is in flight the bridge holds its upstream stall high, so no second request can overlap the first.

Top module: `wide_narrow_bridge`

## Requirements
- R1: An upstream request is accepted on a rising clock edge where `up_cyc` and `up_stb` are high and `up_stall` is low; `up_stall` is low whenever no request is in flight.
- R2: From the cycle after acceptance until the cycle in which `up_ack` is high, `up_stall` stays high; it is low again in the `up_ack` cycle.
- R3: When `up_sel[3:0]` and `up_sel[7:4]` both have a bit set, two downstream accesses are made in this order. The first uses byte address `{up_adr,3'b000}`, `dn_sel = up_sel[3:0]` and `dn_dat_w = up_dat_w[31:0]`. The second uses byte address `{up_adr,3'b100}`, `dn_sel = up_sel[7:4]` and `dn_dat_w = up_dat_w[63:32]`.
- R4: When only one half of `up_sel` has bits set, only that half's access from R3 is made. When `up_sel` is all zero, a single low-half access is made with `dn_sel = 4'b0000`.
- R5: Every downstream field (`dn_adr`, `dn_sel`, `dn_dat_w`, `dn_we`) comes from values registered at acceptance. Changes on the upstream lines after acceptance have no effect on them.
- R6: The request data is registered on every acceptance, reads included, so a read's downstream accesses carry the matching halves of `up_dat_w` on `dn_dat_w`.
- R7: A read that makes two accesses returns `up_dat_r = {second data, first data}`. A low-only read returns `{32'h0, data}` and a high-only read returns `{data, 32'h0}`.
- R8: `up_ack` is a single-cycle pulse one cycle after the final `dn_ack`. With downstream stall of s cycles per access and ack one cycle after each downstream acceptance, the upstream ack comes n*(2+s) cycles after the acceptance edge, where n is the number of accesses.
- R9: `dn_stb` and the downstream address and selects hold steady while `dn_stall` is high. `dn_cyc` stays high from the first access until the final `dn_ack`.
- R10: A synchronous active-high `rst` returns the bridge to idle on the next edge, even mid-transaction. After that edge `dn_cyc`, `dn_stb`, `up_ack` and `up_stall` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_cyc | input | 1 | Upstream cycle valid |
| up_stb | input | 1 | Upstream request strobe |
| up_we | input | 1 | Upstream write enable |
| up_adr | input | 13 | Upstream 64-bit word address |
| up_dat_w | input | 64 | Upstream write data |
| up_sel | input | 8 | Upstream byte selects |
| up_stall | output | 1 | Upstream stall, high while busy |
| up_ack | output | 1 | Upstream acknowledge pulse |
| up_dat_r | output | 64 | Upstream read data |
| dn_cyc | output | 1 | Downstream cycle valid |
| dn_stb | output | 1 | Downstream request strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_adr | output | 16 | Downstream byte address |
| dn_dat_w | output | 32 | Downstream write data |
| dn_sel | output | 4 | Downstream byte selects |
| dn_stall | input | 1 | Downstream stall |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_dat_r | input | 32 | Downstream read data |

## Verification
A request register that is loaded late or from the wrong source shows up at the ports right away. The second downstream access of a store then carries whatever the upstream lines held one cycle after acceptance, and the bench deliberately scrambles those lines. A sequencer that loses track of its remaining half shows up within a few cycles: the access count is wrong, the order is wrong, or the upstream ack comes early or late against the n*(2+s) latency. A lost first-half read register shows up in the very acknowledge cycle as a wrong low word in `up_dat_r`.

// File: rtl/wnb_pkg.sv
package wnb_pkg;
    localparam int HALF_W   = 32;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int HALF_SEL = HALF_W / 8;
    localparam int WORD_SEL = WORD_W / 8;
    localparam int UP_AW    = 13;
    localparam int LANE_SH  = $clog2(HALF_SEL);
    localparam int DN_AW    = UP_AW + 1 + LANE_SH;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic                we;
        logic [UP_AW-1:0]    adr;
        logic [WORD_W-1:0]   dat;
        logic [WORD_SEL-1:0] sel;
    } up_req_t;

    function automatic logic lane_used(input logic [WORD_SEL-1:0] sel, input logic hi);
        return hi ? (|sel[WORD_SEL-1:HALF_SEL]) : (|sel[HALF_SEL-1:0]);
    endfunction
endpackage

// File: rtl/wnb_capture.sv
module wnb_capture
    import wnb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  up_req_t req_in,
    output up_req_t req_q
);
    // Loaded on every acceptance, whatever the write flag says.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/wnb_sequencer.sv
module wnb_sequencer
    import wnb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [WORD_SEL-1:0] sel_in,
    input  logic                dn_stall,
    input  logic                dn_ack,
    output logic                busy,
    output logic                dn_cyc,
    output logic                dn_stb,
    output logic                cur_hi,
    output logic                lo_done,
    output logic                fin
);
    seq_state_t state_q;
    logic       more_q;
    logic       use_lo;
    logic       use_hi;

    assign use_lo = lane_used(sel_in, 1'b0);
    assign use_hi = lane_used(sel_in, 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            more_q  <= 1'b0;
            cur_hi  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_ISSUE;
                        if (use_lo || !use_hi) begin
                            cur_hi <= 1'b0;
                            more_q <= use_hi;
                        end else begin
                            cur_hi <= 1'b1;
                            more_q <= 1'b0;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (!dn_stall) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dn_ack) begin
                        if (more_q) begin
                            cur_hi  <= 1'b1;
                            more_q  <= 1'b0;
                            state_q <= ST_ISSUE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign dn_cyc  = busy;
    assign dn_stb  = (state_q == ST_ISSUE);
    assign lo_done = (state_q == ST_WAIT) && dn_ack && more_q;
    assign fin     = (state_q == ST_WAIT) && dn_ack && !more_q;
endmodule

// File: rtl/wnb_merge.sv
module wnb_merge
    import wnb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_done,
    input  logic              fin,
    input  logic              cur_hi,
    input  logic [HALF_W-1:0] dn_dat_r,
    output logic              up_ack,
    output logic [WORD_W-1:0] up_dat_r
);
    logic [HALF_W-1:0] lo_q;
    logic              lo_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_ack   <= 1'b0;
            up_dat_r <= '0;
            lo_q     <= '0;
            lo_valid <= 1'b0;
        end else begin
            up_ack <= fin;
            if (lo_done) begin
                lo_q     <= dn_dat_r;
                lo_valid <= 1'b1;
            end
            if (fin) begin
                lo_valid <= 1'b0;
                if (cur_hi) begin
                    up_dat_r <= {dn_dat_r, (lo_valid ? lo_q : {HALF_W{1'b0}})};
                end else begin
                    up_dat_r <= {{HALF_W{1'b0}}, dn_dat_r};
                end
            end
        end
    end
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge
    import wnb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                up_cyc,
    input  logic                up_stb,
    input  logic                up_we,
    input  logic [UP_AW-1:0]    up_adr,
    input  logic [WORD_W-1:0]   up_dat_w,
    input  logic [WORD_SEL-1:0] up_sel,
    output logic                up_stall,
    output logic                up_ack,
    output logic [WORD_W-1:0]   up_dat_r,
    output logic                dn_cyc,
    output logic                dn_stb,
    output logic                dn_we,
    output logic [DN_AW-1:0]    dn_adr,
    output logic [HALF_W-1:0]   dn_dat_w,
    output logic [HALF_SEL-1:0] dn_sel,
    input  logic                dn_stall,
    input  logic                dn_ack,
    input  logic [HALF_W-1:0]   dn_dat_r
);
    localparam int NUM_LANES = WORD_W / HALF_W;

    up_req_t req_in;
    up_req_t req_q;
    logic    busy;
    logic    accept;
    logic    cur_hi;
    logic    lo_done;
    logic    fin;

    logic [HALF_W-1:0]   lane_dat [NUM_LANES];
    logic [HALF_SEL-1:0] lane_sel [NUM_LANES];

    assign req_in = '{we: up_we, adr: up_adr, dat: up_dat_w, sel: up_sel};
    assign accept = up_cyc && up_stb && !busy;
    assign up_stall = busy;

    wnb_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    wnb_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .sel_in   (up_sel),
        .dn_stall (dn_stall),
        .dn_ack   (dn_ack),
        .busy     (busy),
        .dn_cyc   (dn_cyc),
        .dn_stb   (dn_stb),
        .cur_hi   (cur_hi),
        .lo_done  (lo_done),
        .fin      (fin)
    );

    wnb_merge u_mrg (
        .clk      (clk),
        .rst      (rst),
        .lo_done  (lo_done),
        .fin      (fin),
        .cur_hi   (cur_hi),
        .dn_dat_r (dn_dat_r),
        .up_ack   (up_ack),
        .up_dat_r (up_dat_r)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_dat[g] = req_q.dat[g*HALF_W +: HALF_W];
        assign lane_sel[g] = req_q.sel[g*HALF_SEL +: HALF_SEL];
    end

    assign dn_we    = req_q.we;
    assign dn_adr   = {req_q.adr, cur_hi, {LANE_SH{1'b0}}};
    assign dn_dat_w = lane_dat[cur_hi];
    assign dn_sel   = lane_sel[cur_hi];
endmodule

// File: rtl/wide_narrow_bridge_chk.sv
module wide_narrow_bridge_chk
    import wnb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                up_cyc,
    input logic                up_stb,
    input logic                up_stall,
    input logic                up_ack,
    input logic                dn_cyc,
    input logic                dn_stb,
    input logic                dn_stall,
    input logic                dn_ack,
    input logic [DN_AW-1:0]    dn_adr,
    input logic [HALF_SEL-1:0] dn_sel
);
    logic past_rst = 1'b0;
    always_ff @(posedge clk) past_rst <= rst;

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cyc && up_stb && !up_stall) |=> up_stall);

    // R2
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        dn_cyc |-> up_stall);

    // R9
    stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_stb && dn_stall) |=> (dn_stb && $stable(dn_adr) && $stable(dn_sel)));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        up_ack |=> !up_ack);

    // R8
    ack_source_chk: assert property (@(posedge clk) disable iff (rst)
        up_ack |-> (!past_rst && $past(dn_ack)));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        past_rst |-> (!dn_cyc && !dn_stb && !up_ack && !up_stall));
endmodule

bind wide_narrow_bridge wide_narrow_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_cyc   (up_cyc),
    .up_stb   (up_stb),
    .up_stall (up_stall),
    .up_ack   (up_ack),
    .dn_cyc   (dn_cyc),
    .dn_stb   (dn_stb),
    .dn_stall (dn_stall),
    .dn_ack   (dn_ack),
    .dn_adr   (dn_adr),
    .dn_sel   (dn_sel)
);

// File: tb/sim_wide_narrow_bridge.sv
`timescale 1ns/1ps
module sim_wide_narrow_bridge;
    import wnb_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0;
    logic [UP_AW-1:0]    up_adr = '0;
    logic [WORD_W-1:0]   up_dat_w = '0;
    logic [WORD_SEL-1:0] up_sel = '0;
    logic                up_stall, up_ack;
    logic [WORD_W-1:0]   up_dat_r;
    logic                dn_cyc, dn_stb, dn_we;
    logic [DN_AW-1:0]    dn_adr;
    logic [HALF_W-1:0]   dn_dat_w;
    logic [HALF_SEL-1:0] dn_sel;
    logic                dn_stall;
    logic                dn_ack = 1'b0;
    logic [HALF_W-1:0]   dn_dat_r = '0;

    always #4 clk = ~clk;

    wide_narrow_bridge u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc_cnt = 0;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Downstream responder: s stall cycles per access, ack one cycle after acceptance.
    int                  stall_cfg = 0;
    int                  stall_ctr = 0;
    int                  lg_n = 0;
    logic [DN_AW-1:0]    lg_adr [64];
    logic [HALF_W-1:0]   lg_dat [64];
    logic [HALF_SEL-1:0] lg_sel [64];
    logic                lg_we  [64];

    function automatic logic [HALF_W-1:0] rd_pat(input logic [DN_AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    assign dn_stall = (stall_ctr != 0);

    always @(posedge clk) begin
        dn_ack <= 1'b0;
        if (dn_cyc && dn_stb) begin
            if (stall_ctr != 0) begin
                stall_ctr <= stall_ctr - 1;
            end else begin
                lg_adr[lg_n % 64] <= dn_adr;
                lg_dat[lg_n % 64] <= dn_dat_w;
                lg_sel[lg_n % 64] <= dn_sel;
                lg_we[lg_n % 64]  <= dn_we;
                lg_n      <= lg_n + 1;
                dn_ack    <= 1'b1;
                dn_dat_r  <= rd_pat(dn_adr);
                stall_ctr <= stall_cfg;
            end
        end else begin
            stall_ctr <= stall_cfg;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {we, sel, adr, dat, stall}
    localparam int NV = 9;
    localparam logic [87:0] VEC [NV] = '{
        {1'b1, 8'hFF, 13'h0010, 64'h1122334455667788, 2'd0},
        {1'b1, 8'h0F, 13'h0123, 64'hDEADBEEFCAFEF00D, 2'd1},
        {1'b1, 8'hF0, 13'h1FFF, 64'h0123456789ABCDEF, 2'd0},
        {1'b0, 8'hFF, 13'h0042, 64'hA5A5A5A55A5A5A5A, 2'd2},
        {1'b0, 8'h03, 13'h0007, 64'h0F0F0F0FF0F0F0F0, 2'd0},
        {1'b0, 8'h80, 13'h0AAA, 64'h1357924680ACE135, 2'd1},
        {1'b1, 8'h81, 13'h0555, 64'hFEDCBA9876543210, 2'd0},
        {1'b1, 8'h00, 13'h0100, 64'h7777666655554444, 2'd0},
        {1'b0, 8'h18, 13'h0321, 64'h8899AABBCCDDEEFF, 2'd3}
    };

    task automatic run_xfer(input logic we, input logic [7:0] sel, input logic [UP_AW-1:0] adr,
                            input logic [63:0] dat, input int s);
        int base, t0, n, k;
        bit lo, hi;
        logic [DN_AW-1:0] ea [2];
        logic [31:0] ed [2];
        logic [3:0] es [2];
        logic [63:0] erd;
        lo = |sel[3:0];
        hi = |sel[7:4];
        n = 0;
        erd = '0;
        if (lo || !hi) begin
            ea[n] = {adr, 3'b000}; ed[n] = dat[31:0]; es[n] = sel[3:0];
            erd[31:0] = rd_pat(ea[n]); n++;
        end
        if (hi) begin
            ea[n] = {adr, 3'b100}; ed[n] = dat[63:32]; es[n] = sel[7:4];
            erd[63:32] = rd_pat(ea[n]); n++;
        end
        @(negedge clk);
        stall_cfg = s;
        base = lg_n;
        up_cyc = 1; up_stb = 1; up_we = we; up_adr = adr; up_dat_w = dat; up_sel = sel;
        chk(up_stall == 1'b0, "R1 stall low when idle", 64'(up_stall), 64'd0);
        @(negedge clk);
        t0 = cyc_cnt;
        // R5: scramble the upstream lines right after acceptance
        up_stb = 0; up_we = ~we; up_adr = ~adr; up_dat_w = ~dat; up_sel = ~sel;
        chk(up_stall == 1'b1, "R2 stall high after accept", 64'(up_stall), 64'd1);
        while (!up_ack) @(negedge clk);
        chk(up_stall == 1'b0, "R2 stall low in ack cycle", 64'(up_stall), 64'd0);
        chk(cyc_cnt - t0 == n * (2 + s), "R8 ack latency", 64'(cyc_cnt - t0), 64'(n * (2 + s)));
        if (!we) chk(up_dat_r == erd, "R7 read data", up_dat_r, erd);
        chk(lg_n - base == n, "R3/R4 access count", 64'(lg_n - base), 64'(n));
        for (k = 0; k < n && k < lg_n - base; k++) begin
            chk(lg_adr[(base + k) % 64] == ea[k], "R3 address/order", 64'(lg_adr[(base + k) % 64]), 64'(ea[k]));
            chk(lg_sel[(base + k) % 64] == es[k], "R4 selects", 64'(lg_sel[(base + k) % 64]), 64'(es[k]));
            chk(lg_dat[(base + k) % 64] == ed[k], "R5 R6 captured data", 64'(lg_dat[(base + k) % 64]), 64'(ed[k]));
            chk(lg_we[(base + k) % 64] == we, "R5 write flag", 64'(lg_we[(base + k) % 64]), 64'(we));
        end
        up_cyc = 0;
        @(negedge clk);
        chk(up_ack == 1'b0, "R8 single ack pulse", 64'(up_ack), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(dn_cyc == 0 && dn_stb == 0, "R10 reset downstream idle", 64'({dn_cyc, dn_stb}), 64'd0);
        chk(up_ack == 0 && up_stall == 0, "R10 reset upstream idle", 64'({up_ack, up_stall}), 64'd0);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            run_xfer(VEC[i][87], VEC[i][86:79], VEC[i][78:66], VEC[i][65:2], int'(VEC[i][1:0]));
        end
        // R9: cyc held between the halves of a stalled split access
        @(negedge clk);
        stall_cfg = 2;
        up_cyc = 1; up_stb = 1; up_we = 1; up_adr = 13'h0077; up_sel = 8'hFF; up_dat_w = 64'h1;
        @(negedge clk);
        up_stb = 0;
        repeat (5) begin
            @(negedge clk);
            chk(dn_cyc == 1'b1, "R9 cyc held during split", 64'(dn_cyc), 64'd1);
        end
        while (!up_ack) @(negedge clk);
        up_cyc = 0;
        // R10: reset in the middle of a split transfer
        @(negedge clk);
        stall_cfg = 3;
        up_cyc = 1; up_stb = 1; up_we = 1; up_adr = 13'h0200; up_sel = 8'hFF; up_dat_w = 64'h2;
        @(negedge clk);
        up_stb = 0; up_cyc = 0;
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(dn_cyc == 0 && dn_stb == 0, "R10 mid-transfer reset downstream", 64'({dn_cyc, dn_stb}), 64'd0);
        chk(up_stall == 0 && up_ack == 0, "R10 mid-transfer reset upstream", 64'({up_stall, up_ack}), 64'd0);
        repeat (4) @(negedge clk);
        run_xfer(1'b1, 8'h3C, 13'h0BEE, 64'hCAFE0000BEEF1111, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule